// File: doc/BRIEF.md
# HDB3 Line Violation Counter

This block monitors a decoded E3 line one pulse at a time. Each cycle it may see a positive mark strobe, a negative mark strobe and a flag. The flag says whether the current mark belongs to a recognised HDB3 substitution codeword. From these inputs the block finds bipolar violations and code violations. It adds the selected kind of event to a 16-bit live counter that saturates instead of wrapping.

A mode input picks what is counted: single bipolar violations, or code violations, which are pairs of successive violations with the same polarity. A line-mode input marks the line as E3 or DS3. In DS3 mode the violation logic is idle and the counter does not advance.

A one-cycle latch pulse copies the live count into a holding register and restarts the live count. The holding register is the only count visible at the ports.

Top module: `hdb3ViolationCounter`

## Requirements
- R1: After reset the holding register reads 0, and a latch with no intervening events also reads 0. The polarity history starts as "no previous mark".
- R2: A mark is a cycle with exactly one of posMark and negMark high; its polarity is negative when negMark is high. A cycle with both strobes high, or with neither, is not a mark and leaves the polarity history unchanged.
- R3: A bipolar violation is a mark whose polarity equals the polarity of the previous mark, where the current mark does not have inCodeword high.
- R4: A mark with inCodeword high is never a violation, but it still becomes the new previous mark.
- R5: A code violation is a bipolar violation whose polarity equals that of the previous bipolar violation. The last-violation polarity is updated on every bipolar violation, so three same-polarity violations in a row yield two code violations.
- R6: With cvSelect = 0 each bipolar violation adds one to the count. With cvSelect = 1 only code violations add one.
- R7: With e3Mode = 0 (DS3) nothing is counted, whatever cvSelect is, and the polarity history is held at "no previous mark". After returning to e3Mode = 1, the first mark has no predecessor.
- R8: The live count saturates at 65535 and does not wrap.
- R9: In a cycle with latchPulse high, the live count moves to the holding register and the live count restarts. A counted event in that same cycle makes the new live count 1.
- R10: Idle cycles between marks do not clear the last-mark or last-violation polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| posMark | input | 1 | Positive mark strobe |
| negMark | input | 1 | Negative mark strobe |
| inCodeword | input | 1 | Current mark is part of an HDB3 substitution codeword |
| e3Mode | input | 1 | 1 = E3 line, 0 = DS3 line (violation logic idle) |
| cvSelect | input | 1 | 0 = count bipolar violations, 1 = count code violations |
| latchPulse | input | 1 | One-cycle strobe: move the live count to the holding register |
| holdCount | output | 16 | Count captured at the last latch |

## Verification
The hardest condition to reach is the saturation boundary. It needs more than 65535 counted events in a single interval. The bench gets there by clearing the history and then driving an unbroken run of same-polarity marks, so that every mark after the first is a violation. It then latches twice: once to see the clamp, and once to confirm that the live count restarted. A code-violation count also needs a specific history of two distinct polarities, so the bench clears the history through a DS3 cycle before each scenario.

// File: rtl/hdb3_vc_pkg.sv
package hdb3_vc_pkg;
  localparam int COUNT_W = 16;

  typedef struct packed {
    logic countEvent;
    logic latch;
  } vcStrobes_t;
endpackage

// File: rtl/hdb3_vc_detector.sv
module hdb3_vc_detector
  import hdb3_vc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       posMark,
  input  logic       negMark,
  input  logic       inCodeword,
  input  logic       e3Mode,
  input  logic       cvSelect,
  input  logic       latchPulse,
  output vcStrobes_t strobes
);
  logic lastMarkValid, lastMarkNeg;
  logic lastBpvValid, lastBpvNeg;
  logic isMark, markNeg, bpvHit, cvHit;

  always_comb begin
    isMark  = posMark ^ negMark;
    markNeg = negMark;
    bpvHit  = e3Mode && isMark && lastMarkValid &&
              (lastMarkNeg == markNeg) && !inCodeword;
    cvHit   = bpvHit && lastBpvValid && (lastBpvNeg == markNeg);
    strobes.countEvent = cvSelect ? cvHit : bpvHit;
    strobes.latch      = latchPulse;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !e3Mode) begin
      lastMarkValid <= 1'b0;
      lastMarkNeg   <= 1'b0;
      lastBpvValid  <= 1'b0;
      lastBpvNeg    <= 1'b0;
    end else if (isMark) begin
      lastMarkValid <= 1'b1;
      lastMarkNeg   <= markNeg;
      if (bpvHit) begin
        lastBpvValid <= 1'b1;
        lastBpvNeg   <= markNeg;
      end
    end
  end

  // R2
  both_strobes_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (posMark && negMark && e3Mode) |=> ($stable(lastMarkValid) && $stable(lastMarkNeg)));

  // R4
  codeword_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    inCodeword |-> !strobes.countEvent);

  // R7
  ds3_history_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !e3Mode |=> (!lastMarkValid && !lastBpvValid));
endmodule

// File: rtl/hdb3_vc_counter.sv
module hdb3_vc_counter
  import hdb3_vc_pkg::*;
#(
  parameter int WIDTH = COUNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  vcStrobes_t       strobes,
  output logic [WIDTH-1:0] holdCount
);
  localparam logic [WIDTH-1:0] MAX_COUNT = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE       = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] liveCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveCount <= '0;
      holdCount <= '0;
    end else if (strobes.latch) begin
      holdCount <= liveCount;
      liveCount <= strobes.countEvent ? ONE : '0;
    end else if (strobes.countEvent && liveCount != MAX_COUNT) begin
      liveCount <= liveCount + ONE;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (liveCount == MAX_COUNT && !strobes.latch) |=> liveCount == MAX_COUNT);

  // R9
  latch_transfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latch |=> holdCount == $past(liveCount));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.countEvent && !strobes.latch && liveCount != MAX_COUNT)
      |=> liveCount == $past(liveCount) + ONE);
endmodule

// File: rtl/hdb3ViolationCounter.sv
module hdb3ViolationCounter
  import hdb3_vc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               posMark,
  input  logic               negMark,
  input  logic               inCodeword,
  input  logic               e3Mode,
  input  logic               cvSelect,
  input  logic               latchPulse,
  output logic [COUNT_W-1:0] holdCount
);
  vcStrobes_t strobes;

  hdb3_vc_detector u_detector (
    .clk(clk), .rstN(rstN), .posMark(posMark), .negMark(negMark),
    .inCodeword(inCodeword), .e3Mode(e3Mode), .cvSelect(cvSelect),
    .latchPulse(latchPulse), .strobes(strobes)
  );

  hdb3_vc_counter #(.WIDTH(COUNT_W)) u_counter (
    .clk(clk), .rstN(rstN), .strobes(strobes), .holdCount(holdCount)
  );
endmodule

// File: tb/tb_hdb3ViolationCounter.sv
module tb_hdb3ViolationCounter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic posMark = 1'b0, negMark = 1'b0, inCodeword = 1'b0;
  logic e3Mode = 1'b1, cvSelect = 1'b0, latchPulse = 1'b0;
  logic [15:0] holdCount;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hdb3ViolationCounter dut (
    .clk(clk), .rstN(rstN), .posMark(posMark), .negMark(negMark),
    .inCodeword(inCodeword), .e3Mode(e3Mode), .cvSelect(cvSelect),
    .latchPulse(latchPulse), .holdCount(holdCount)
  );

  task automatic drive(input logic p, input logic n, input logic cw, input logic lat);
    @(negedge clk);
    posMark = p; negMark = n; inCodeword = cw; latchPulse = lat;
  endtask

  task automatic check(input int expv, input string tag);
    nChecks++;
    if (holdCount !== 16'(expv)) begin
      nFails++;
      $display("FAIL %s: holdCount=%0d expected=%0d", tag, holdCount, expv);
    end
  endtask

  task automatic latchCheck(input int expv, input string tag);
    drive(0, 0, 0, 1);
    @(negedge clk);
    latchPulse = 0;
    check(expv, tag);
  endtask

  task automatic clearHist();
    @(negedge clk);
    posMark = 0; negMark = 0; inCodeword = 0; latchPulse = 0; e3Mode = 0;
    @(negedge clk);
    e3Mode = 1;
  endtask

  task automatic testReset();
    check(0, "R1 reset value");
    latchCheck(0, "R1 empty interval");
  endtask

  task automatic testBpv();
    clearHist(); cvSelect = 0;
    drive(1,0,0,0); drive(0,1,0,0); drive(1,0,0,0); drive(1,0,0,0);
    drive(0,0,0,0); drive(0,0,0,0);
    drive(1,0,0,0); drive(0,1,0,0); drive(0,1,0,0);
    latchCheck(3, "R3 R10 bipolar count with gaps");
  endtask

  task automatic testCodeword();
    clearHist(); cvSelect = 0;
    drive(1,0,0,0); drive(1,0,1,0); drive(0,1,0,0); drive(0,1,1,0); drive(0,1,0,0);
    latchCheck(1, "R4 codeword marks exempt but tracked");
  endtask

  task automatic testBoth();
    clearHist(); cvSelect = 0;
    drive(1,0,0,0); drive(1,1,0,0); drive(1,1,0,0); drive(0,1,0,0);
    latchCheck(0, "R2 dual strobe is not a mark");
    clearHist();
    drive(1,0,0,0); drive(1,1,0,0); drive(1,0,0,0);
    latchCheck(1, "R2 dual strobe leaves history");
  endtask

  task automatic testCv();
    clearHist(); cvSelect = 1;
    drive(1,0,0,0); drive(1,0,0,0); drive(0,1,0,0); drive(1,0,0,0); drive(1,0,0,0);
    drive(0,0,0,0); drive(1,0,0,0);
    latchCheck(2, "R5 R6 code violations");
    clearHist();
    drive(1,0,0,0); drive(1,0,0,0); drive(0,1,0,0); drive(0,1,0,0);
    latchCheck(0, "R5 opposite-polarity violations");
    cvSelect = 0;
  endtask

  task automatic testDs3();
    clearHist();
    @(negedge clk); e3Mode = 0;
    cvSelect = 0; drive(1,0,0,0); drive(1,0,0,0); drive(1,0,0,0);
    cvSelect = 1; drive(0,1,0,0); drive(0,1,0,0);
    latchCheck(0, "R7 DS3 counts nothing");
    @(negedge clk); e3Mode = 1; cvSelect = 0;
    drive(0,1,0,0);
    latchCheck(0, "R7 first mark after DS3 has no predecessor");
    drive(0,1,0,0);
    latchCheck(1, "R7 counting resumes in E3");
  endtask

  task automatic testLatchSame();
    clearHist(); cvSelect = 0;
    drive(1,0,0,0); drive(1,0,0,0); drive(1,0,0,1);
    @(negedge clk); latchPulse = 0; posMark = 0;
    check(1, "R9 latch captures prior count");
    latchCheck(1, "R9 coincident event joins new interval");
  endtask

  task automatic testSaturate();
    clearHist(); cvSelect = 0;
    for (int i = 0; i < 65540; i++) drive(1,0,0,0);
    latchCheck(65535, "R8 saturation");
    latchCheck(0, "R9 live count restarted after latch");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testBpv();
    testCodeword();
    testBoth();
    testCv();
    testDs3();
    testLatchSame();
    testSaturate();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule